// File: doc/BRIEF.md
# Bitmap Line-Draw Stepper

This block walks a straight line across a word-organised bitmap, one pixel per step, on behalf of a block-transfer engine running in line mode. It keeps a signed error accumulator, the pixel's bit position inside the current 16-bit word, and the byte address of that word. On every step the major axis advances by one pixel. The sign of the accumulator decides whether the minor axis advances as well and which of two modulo values is added to the accumulator.

For each step the block hands three operands to an external logic-function combiner. The first is a pixel mask: the A data word shifted right by the pixel position. The second is a texture operand, all ones or all zeros, taken from bit 0 of a rotating pattern. The third is the destination word just read. The block then writes the combiner's result back, so every pixel is a read-modify-write of one destination word. The memory side uses plain request/acknowledge handshakes.

A line is set up by presenting the configuration inputs together with a one-cycle start pulse. The block is busy until the requested number of steps has been committed, and then it raises a one-cycle done pulse.

Top module: `line_stepper`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, rd_req and wr_req are all low until a start is accepted.
- R2: A step occupies four slots in this fixed order: an idle slot, a read of the current word, an idle slot, and a write. A read or write request stays high with a stable address until it is acknowledged, and the operand C output shows the word returned by the read.
- R3: The mask operand equals the A word shifted right by the current pixel position (0 to 15). The position starts at cfg_a_pos.
- R4: An x step that increments from position 15 wraps to 0 and adds 2 to the word address. An x step that decrements from position 0 wraps to 15 and subtracts 2. Any other x step changes only the position.
- R5: A y step adds the sign-extended cfg_c_mod to the word address, or subtracts it when the y direction is downward.
- R6: When the accumulator sign is clear, cfg_a_mod is added to the accumulator and the minor axis steps. When the sign is set, cfg_b_mod is added and the minor axis holds. The new sign is bit 15 of the sum, and the starting sign is cfg_neg.
- R7: The major axis steps on every step. cfg_minor_y=1 makes y the minor axis and x the major axis; cfg_minor_y=0 swaps them. cfg_minor_down=1 makes minor steps decrement, and cfg_major_down=1 makes major steps decrement.
- R8: The texture pattern starts as cfg_b_word rotated right by cfg_b_rot and rotates left by one bit after every step. The texture operand is 16'hFFFF when pattern bit 0 is 1 and 16'h0000 when it is 0.
- R9: With cfg_single=1, the mask is zero on every step after the first one since the last y step. The first step of a line counts as a fresh row.
- R10: The first write of a line goes to cfg_d_ptr. Every later write goes to the address read in the same step. The write data is cmb_data.
- R11: With cfg_c_en=0 the line still takes four cycles per step, but no read or write request is ever raised.
- R12: The line ends after exactly cfg_steps committed steps, with done high for one cycle in the cycle after the last write completes. A start with cfg_steps=0, or with cfg_width other than 2, raises done in the next cycle and performs no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts a line (only taken while idle) |
| cfg_width | input | 6 | Word-width field; must be 2 for a line to run |
| cfg_steps | input | 10 | Number of pixels to plot |
| cfg_minor_y | input | 1 | 1: y is the minor axis; 0: x is the minor axis |
| cfg_minor_down | input | 1 | Minor axis decrements |
| cfg_major_down | input | 1 | Major axis decrements |
| cfg_single | input | 1 | One pixel per row |
| cfg_neg | input | 1 | Initial accumulator sign |
| cfg_c_en | input | 1 | Enables destination read and write traffic |
| cfg_a_pos | input | 4 | Initial pixel position in the word |
| cfg_b_rot | input | 4 | Right rotation applied to the texture at load |
| cfg_a_word | input | 16 | Pixel word that is shifted to form the mask |
| cfg_b_word | input | 16 | Texture pattern |
| cfg_err | input | 16 | Initial accumulator value |
| cfg_a_mod | input | 16 | Accumulator increment when the sign is clear |
| cfg_b_mod | input | 16 | Accumulator increment when the sign is set |
| cfg_c_mod | input | 16 | Signed row pitch in bytes |
| cfg_c_ptr | input | 20 | Starting word address |
| cfg_d_ptr | input | 20 | Address of the first write |
| busy | output | 1 | Line in progress |
| done | output | 1 | One-cycle end-of-line pulse |
| rd_req | output | 1 | Read request |
| rd_addr | output | 20 | Read address |
| rd_ack | input | 1 | Read acknowledge, with rd_data valid |
| rd_data | input | 16 | Read data |
| op_mask | output | 16 | Mask operand for the combiner |
| op_tex | output | 16 | Texture operand for the combiner |
| op_c | output | 16 | Destination word operand |
| cmb_data | input | 16 | Combiner result |
| wr_req | output | 1 | Write request |
| wr_addr | output | 20 | Write address |
| wr_data | output | 16 | Write data |
| wr_ack | input | 1 | Write acknowledge |

## Verification
The line walk is driven with five configurations. The first is an x-major line that increments and crosses a word boundary upward. The second is a y-major line that decrements on both axes and wraps below position 0 on its first minor step. The third is a single-dot line whose accumulator starts negative and later turns non-negative, so the row reset can be seen. The fourth is a line with destination traffic disabled. The fifth is an x-major line that decrements on both axes and whose texture starts at zero. Each step's read address is compared against an independent walk of the accumulator, position and address, so mistakes in sign handling, axis choice, wrap direction and pitch sign show up as different addresses. Mask, texture and write-address checks separate the shift, the rotation and the first-write redirection. Acknowledge delays of zero to two cycles exercise request holding.

// File: rtl/lstep_pkg.sv
package lstep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_READ  = 3'd2,
    ST_GAP   = 3'd3,
    ST_WRITE = 3'd4
  } step_state_e;

  typedef struct packed {
    logic minor_is_y;
    logic minor_down;
    logic major_down;
  } octant_t;

endpackage

// File: rtl/lstep_accum.sv
// Error accumulator step: picks the modulo by sign, reports whether the
// minor axis moves, and derives the new sign from the sum.
module lstep_accum #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] acc,
  input  logic          neg,
  input  logic [DW-1:0] a_mod,
  input  logic [DW-1:0] b_mod,
  output logic [DW-1:0] acc_nxt,
  output logic          neg_nxt,
  output logic          minor_go
);

  always_comb begin
    minor_go = ~neg;
    acc_nxt  = neg ? (acc + b_mod) : (acc + a_mod);
    neg_nxt  = acc_nxt[DW-1];
  end

endmodule

// File: rtl/lstep_walk.sv
// Position and address update for one step.
module lstep_walk
  import lstep_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 20,
  localparam int unsigned PW = $clog2(DW)
) (
  input  logic [AW-1:0] addr,
  input  logic [PW-1:0] pos,
  input  octant_t       oct,
  input  logic          minor_go,
  input  logic [DW-1:0] c_mod,
  output logic [AW-1:0] addr_nxt,
  output logic [PW-1:0] pos_nxt,
  output logic          y_moved
);

  localparam logic [AW-1:0] WORD_STEP = AW'(DW / 8);
  localparam logic [PW-1:0] POS_LAST  = PW'(DW - 1);

  logic [AW-1:0] pitch;
  logic [AW-1:0] x_off;
  logic [AW-1:0] y_off;
  logic          x_do;
  logic          x_down;
  logic          y_do;
  logic          y_down;

  generate
    if (AW > DW) begin : g_sext
      assign pitch = {{(AW-DW){c_mod[DW-1]}}, c_mod};
    end else begin : g_trunc
      assign pitch = c_mod[AW-1:0];
    end
  endgenerate

  always_comb begin
    if (oct.minor_is_y) begin
      x_do   = 1'b1;
      x_down = oct.major_down;
      y_do   = minor_go;
      y_down = oct.minor_down;
    end else begin
      x_do   = minor_go;
      x_down = oct.minor_down;
      y_do   = 1'b1;
      y_down = oct.major_down;
    end
  end

  always_comb begin
    pos_nxt = pos;
    x_off   = '0;
    if (x_do) begin
      if (x_down) begin
        if (pos == '0) begin
          pos_nxt = POS_LAST;
          x_off   = -WORD_STEP;
        end else begin
          pos_nxt = pos - PW'(1);
        end
      end else begin
        if (pos == POS_LAST) begin
          pos_nxt = '0;
          x_off   = WORD_STEP;
        end else begin
          pos_nxt = pos + PW'(1);
        end
      end
    end
  end

  always_comb begin
    if (!y_do)       y_off = '0;
    else if (y_down) y_off = -pitch;
    else             y_off = pitch;
    y_moved  = y_do;
    addr_nxt = addr + x_off + y_off;
  end

endmodule

// File: rtl/lstep_shape.sv
// Operand shaping: pixel mask, texture operand, texture rotation and the
// load-time right rotation of the texture word (DW must be a power of two).
module lstep_shape #(
  parameter int unsigned DW = 16,
  localparam int unsigned PW = $clog2(DW)
) (
  input  logic [DW-1:0] a_word,
  input  logic [PW-1:0] pos,
  input  logic          single,
  input  logic          dot_done,
  input  logic [DW-1:0] tex,
  input  logic [DW-1:0] b_raw,
  input  logic [PW-1:0] b_rot,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] tex_op,
  output logic [DW-1:0] tex_rot,
  output logic [DW-1:0] tex_load
);

  always_comb begin
    mask    = (single && dot_done) ? '0 : (a_word >> pos);
    tex_op  = {DW{tex[0]}};
    tex_rot = {tex[DW-2:0], tex[DW-1]};
  end

  genvar g;
  generate
    for (g = 0; g < DW; g++) begin : g_rot
      assign tex_load[g] = b_raw[PW'(g) + b_rot];
    end
  endgenerate

endmodule

// File: rtl/lstep_seq.sv
// Slot sequencer: idle, read, idle, write per step, plus step counting.
module lstep_seq
  import lstep_pkg::*;
#(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cfg_ok,
  input  logic [CW-1:0] line_cnt,
  input  logic          c_en,
  input  logic          rd_ack,
  input  logic          wr_ack,
  output logic          busy,
  output logic          rd_req,
  output logic          wr_req,
  output logic          load,
  output logic          commit,
  output logic          done
);

  step_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          done_q, done_d;
  logic          reject;
  logic          last;

  always_comb begin
    load   = (state_q == ST_IDLE) && start && cfg_ok;
    reject = (state_q == ST_IDLE) && start && !cfg_ok;
    commit = (state_q == ST_WRITE) && (!c_en || wr_ack);
    last   = (cnt_q == CW'(1));

    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (load) state_d = ST_LEAD;
      ST_LEAD:  state_d = ST_READ;
      ST_READ:  if (!c_en || rd_ack) state_d = ST_GAP;
      ST_GAP:   state_d = ST_WRITE;
      ST_WRITE: if (commit) state_d = last ? ST_IDLE : ST_LEAD;
      default:  state_d = ST_IDLE;
    endcase

    cnt_en = load || commit;
    cnt_d  = load ? line_cnt : (cnt_q - CW'(1));
    done_d = reject || (commit && last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign rd_req = (state_q == ST_READ) && c_en;
  assign wr_req = (state_q == ST_WRITE) && c_en;
  assign done   = done_q;

endmodule

// File: rtl/line_stepper.sv
module line_stepper
  import lstep_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 20,
  parameter int unsigned CW = 10,
  parameter int unsigned WW = 6,
  localparam int unsigned PW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [WW-1:0] cfg_width,
  input  logic [CW-1:0] cfg_steps,
  input  logic          cfg_minor_y,
  input  logic          cfg_minor_down,
  input  logic          cfg_major_down,
  input  logic          cfg_single,
  input  logic          cfg_neg,
  input  logic          cfg_c_en,
  input  logic [PW-1:0] cfg_a_pos,
  input  logic [PW-1:0] cfg_b_rot,
  input  logic [DW-1:0] cfg_a_word,
  input  logic [DW-1:0] cfg_b_word,
  input  logic [DW-1:0] cfg_err,
  input  logic [DW-1:0] cfg_a_mod,
  input  logic [DW-1:0] cfg_b_mod,
  input  logic [DW-1:0] cfg_c_mod,
  input  logic [AW-1:0] cfg_c_ptr,
  input  logic [AW-1:0] cfg_d_ptr,
  output logic          busy,
  output logic          done,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] op_mask,
  output logic [DW-1:0] op_tex,
  output logic [DW-1:0] op_c,
  input  logic [DW-1:0] cmb_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack
);

  localparam logic [WW-1:0] LINE_WORDS = WW'(2);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic cfg_ok, load, commit, rd_hs;
  assign cfg_ok = (cfg_width == LINE_WORDS) && (cfg_steps != '0);

  // Per-line configuration held for the whole line
  octant_t       oct_q;
  logic          single_q, c_en_q;
  logic [DW-1:0] a_word_q, a_mod_q, b_mod_q, c_mod_q;

  // Walking state
  logic [DW-1:0] acc_q, acc_d;
  logic          neg_q, neg_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] dptr_q;
  logic [DW-1:0] tex_q, tex_d;
  logic          dot_q, dot_d;
  logic          first_q, first_d;
  logic [DW-1:0] c_word_q;
  logic          walk_en;

  // Step results from the datapath units
  logic [DW-1:0] acc_step;
  logic          neg_step, minor_go;
  logic [AW-1:0] addr_step;
  logic [PW-1:0] pos_step;
  logic          y_moved;
  logic [DW-1:0] tex_rot, tex_load, mask, tex_op;

  lstep_seq #(.CW(CW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .cfg_ok   (cfg_ok),
    .line_cnt (cfg_steps),
    .c_en     (c_en_q),
    .rd_ack   (rd_ack),
    .wr_ack   (wr_ack),
    .busy     (busy),
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .load     (load),
    .commit   (commit),
    .done     (done)
  );

  lstep_accum #(.DW(DW)) u_accum (
    .acc      (acc_q),
    .neg      (neg_q),
    .a_mod    (a_mod_q),
    .b_mod    (b_mod_q),
    .acc_nxt  (acc_step),
    .neg_nxt  (neg_step),
    .minor_go (minor_go)
  );

  lstep_walk #(.DW(DW), .AW(AW)) u_walk (
    .addr     (addr_q),
    .pos      (pos_q),
    .oct      (oct_q),
    .minor_go (minor_go),
    .c_mod    (c_mod_q),
    .addr_nxt (addr_step),
    .pos_nxt  (pos_step),
    .y_moved  (y_moved)
  );

  lstep_shape #(.DW(DW)) u_shape (
    .a_word   (a_word_q),
    .pos      (pos_q),
    .single   (single_q),
    .dot_done (dot_q),
    .tex      (tex_q),
    .b_raw    (cfg_b_word),
    .b_rot    (cfg_b_rot),
    .mask     (mask),
    .tex_op   (tex_op),
    .tex_rot  (tex_rot),
    .tex_load (tex_load)
  );

  // Next-state selection: load a new line or commit one step
  always_comb begin
    walk_en = load || commit;
    if (load) begin
      acc_d   = cfg_err;
      neg_d   = cfg_neg;
      pos_d   = cfg_a_pos;
      addr_d  = cfg_c_ptr;
      tex_d   = tex_load;
      dot_d   = 1'b0;
      first_d = 1'b1;
    end else begin
      acc_d   = acc_step;
      neg_d   = neg_step;
      pos_d   = pos_step;
      addr_d  = addr_step;
      tex_d   = tex_rot;
      dot_d   = ~y_moved;
      first_d = 1'b0;
    end
    rd_hs = rd_req && rd_ack;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      oct_q    <= '0;
      single_q <= 1'b0;
      c_en_q   <= 1'b0;
      a_word_q <= '0;
      a_mod_q  <= '0;
      b_mod_q  <= '0;
      c_mod_q  <= '0;
      dptr_q   <= '0;
    end else if (load) begin
      oct_q    <= '{minor_is_y: cfg_minor_y, minor_down: cfg_minor_down,
                    major_down: cfg_major_down};
      single_q <= cfg_single;
      c_en_q   <= cfg_c_en;
      a_word_q <= cfg_a_word;
      a_mod_q  <= cfg_a_mod;
      b_mod_q  <= cfg_b_mod;
      c_mod_q  <= cfg_c_mod;
      dptr_q   <= cfg_d_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q   <= '0;
      neg_q   <= 1'b0;
      pos_q   <= '0;
      addr_q  <= '0;
      tex_q   <= '0;
      dot_q   <= 1'b0;
      first_q <= 1'b0;
    end else if (walk_en) begin
      acc_q   <= acc_d;
      neg_q   <= neg_d;
      pos_q   <= pos_d;
      addr_q  <= addr_d;
      tex_q   <= tex_d;
      dot_q   <= dot_d;
      first_q <= first_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) c_word_q <= '0;
    else if (rd_hs)  c_word_q <= rd_data;
  end

  assign rd_addr = addr_q;
  assign wr_addr = first_q ? dptr_q : addr_q;
  assign wr_data = cmb_data;
  assign op_mask = mask;
  assign op_tex  = tex_op;
  assign op_c    = c_word_q;

endmodule

// File: rtl/line_stepper_chk.sv
module line_stepper_chk #(
  parameter int unsigned AW = 20,
  parameter int unsigned CW = 10,
  parameter int unsigned WW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [WW-1:0] cfg_width,
  input logic [CW-1:0] cfg_steps,
  input logic          busy,
  input logic          done,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [AW-1:0] rd_addr,
  input logic          wr_req,
  input logic          wr_ack,
  input logic [AW-1:0] wr_addr,
  input logic          c_en
);

  a_r2_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  a_r2_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr));

  a_r2_gap_slot: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ack |=> !rd_req && !wr_req);

  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !c_en |-> !rd_req && !wr_req);

  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r12_reject: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (cfg_width != WW'(2) || cfg_steps == '0) |=> done && !busy);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req && !wr_req);

endmodule

bind line_stepper line_stepper_chk #(.AW(AW), .CW(CW), .WW(WW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .cfg_width (cfg_width),
  .cfg_steps (cfg_steps),
  .busy      (busy),
  .done      (done),
  .rd_req    (rd_req),
  .rd_ack    (rd_ack),
  .rd_addr   (rd_addr),
  .wr_req    (wr_req),
  .wr_ack    (wr_ack),
  .wr_addr   (wr_addr),
  .c_en      (c_en_q)
);

// File: tb/test_line_stepper.sv
module test_line_stepper;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [5:0]  cfg_width;
  logic [9:0]  cfg_steps;
  logic        cfg_minor_y, cfg_minor_down, cfg_major_down, cfg_single, cfg_neg, cfg_c_en;
  logic [3:0]  cfg_a_pos, cfg_b_rot;
  logic [15:0] cfg_a_word, cfg_b_word, cfg_err, cfg_a_mod, cfg_b_mod, cfg_c_mod;
  logic [19:0] cfg_c_ptr, cfg_d_ptr;
  logic        busy, done, rd_req, rd_ack, wr_req, wr_ack;
  logic [19:0] rd_addr, wr_addr;
  logic [15:0] rd_data, op_mask, op_tex, op_c, cmb_data, wr_data;

  always #10 clk = ~clk;

  line_stepper i_line_stepper (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width), .cfg_steps(cfg_steps),
    .cfg_minor_y(cfg_minor_y), .cfg_minor_down(cfg_minor_down), .cfg_major_down(cfg_major_down),
    .cfg_single(cfg_single), .cfg_neg(cfg_neg), .cfg_c_en(cfg_c_en), .cfg_a_pos(cfg_a_pos),
    .cfg_b_rot(cfg_b_rot), .cfg_a_word(cfg_a_word), .cfg_b_word(cfg_b_word), .cfg_err(cfg_err),
    .cfg_a_mod(cfg_a_mod), .cfg_b_mod(cfg_b_mod), .cfg_c_mod(cfg_c_mod), .cfg_c_ptr(cfg_c_ptr),
    .cfg_d_ptr(cfg_d_ptr), .busy(busy), .done(done), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .op_mask(op_mask), .op_tex(op_tex), .op_c(op_c),
    .cmb_data(cmb_data), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack)
  );

  typedef struct packed {
    logic        minor_y, minor_down, major_down, single, neg, c_en;
    logic [3:0]  a_pos, b_rot;
    logic [15:0] a_word, b_word, err, a_mod, b_mod, c_mod;
    logic [19:0] c_ptr, d_ptr;
    logic [9:0]  steps;
    logic [1:0]  dly;
    logic [15:0] exp_mask, exp_tex;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 4'd14,4'd4, 16'h8000,16'hF0F0,16'h0003,16'hFFF8,16'h0004,16'h0040,
      20'h01000,20'h02000, 10'd5, 2'd0, 16'h0002,16'hFFFF},
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b1, 4'd0,4'd0, 16'h8000,16'h0001,16'h0001,16'hFFFE,16'h0003,16'h0050,
      20'h03000,20'h04000, 10'd6, 2'd1, 16'h8000,16'hFFFF},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 4'd3,4'd1, 16'h8000,16'h0002,16'hFFF0,16'hFFF0,16'h0008,16'h0028,
      20'h05000,20'h05000, 10'd8, 2'd2, 16'h1000,16'hFFFF},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd5,4'd0, 16'h8000,16'h0000,16'h0000,16'h0001,16'h0001,16'h0010,
      20'h08000,20'h09000, 10'd4, 2'd0, 16'h0400,16'h0000},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 4'd0,4'd1, 16'hFFFF,16'h0004,16'h0000,16'hFFFC,16'h0006,16'h0030,
      20'h06010,20'h07000, 10'd5, 2'd1, 16'hFFFF,16'h0000}
  };

  int n_chk = 0;
  int n_fail = 0;
  bit summary_done = 0;

  // Independent reference walk, written from the requirements
  logic [15:0] m_acc, m_tex;
  logic        m_neg, m_dot, m_first;
  logic [3:0]  m_pos;
  logic [19:0] m_addr;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic m_xstep(input logic down);
    if (down) begin
      if (m_pos == 4'd0) begin m_pos = 4'd15; m_addr = m_addr - 20'd2; end
      else m_pos = m_pos - 4'd1;
    end else begin
      if (m_pos == 4'd15) begin m_pos = 4'd0; m_addr = m_addr + 20'd2; end
      else m_pos = m_pos + 4'd1;
    end
  endtask

  task automatic m_ystep(input logic down, input logic [15:0] cmod);
    logic [19:0] p;
    p = {{4{cmod[15]}}, cmod};
    m_addr = down ? (m_addr - p) : (m_addr + p);
    m_dot  = 1'b0;
  endtask

  // R6 R7: one committed step of the reference walk
  task automatic m_advance(input vec_t v);
    logic go;
    go = !m_neg;
    m_acc = go ? (m_acc + v.a_mod) : (m_acc + v.b_mod);
    m_dot = 1'b1;
    if (v.minor_y) begin
      if (go) m_ystep(v.minor_down, v.c_mod);
      m_xstep(v.major_down);
    end else begin
      if (go) m_xstep(v.minor_down);
      m_ystep(v.major_down, v.c_mod);
    end
    m_neg   = m_acc[15];
    m_tex   = {m_tex[14:0], m_tex[15]};
    m_first = 1'b0;
  endtask

  task automatic load_cfg(input vec_t v, input logic [5:0] width);
    cfg_width = width; cfg_steps = v.steps;
    cfg_minor_y = v.minor_y; cfg_minor_down = v.minor_down; cfg_major_down = v.major_down;
    cfg_single = v.single; cfg_neg = v.neg; cfg_c_en = v.c_en;
    cfg_a_pos = v.a_pos; cfg_b_rot = v.b_rot; cfg_a_word = v.a_word; cfg_b_word = v.b_word;
    cfg_err = v.err; cfg_a_mod = v.a_mod; cfg_b_mod = v.b_mod; cfg_c_mod = v.c_mod;
    cfg_c_ptr = v.c_ptr; cfg_d_ptr = v.d_ptr;
  endtask

  task automatic run_vec(input vec_t v);
    logic [15:0] e_mask, rdv, cmbv;
    logic [19:0] e_wr;
    @(negedge clk);
    load_cfg(v, 6'd2);
    start = 1'b1;
    m_acc = v.err; m_neg = v.neg; m_pos = v.a_pos; m_addr = v.c_ptr;
    m_dot = 1'b0; m_first = 1'b1;
    for (int i = 0; i < 16; i++) m_tex[i] = v.b_word[(i + int'(v.b_rot)) % 16];
    if (!v.c_en) begin
      for (int k = 0; k < 4 * int'(v.steps); k++) begin
        @(negedge clk);
        start = 1'b0;
        if (k == 0) begin
          chk(op_mask == v.exp_mask, "R3 first mask", op_mask, v.exp_mask);
          chk(op_tex == v.exp_tex, "R8 first texture", op_tex, v.exp_tex);
        end
        chk(!rd_req && !wr_req, "R11 no traffic", {rd_req, wr_req}, 0);
        chk(!done && busy, "R11 still stepping", {done, busy}, 1);
      end
      @(negedge clk);
      chk(done && !busy, "R12 done after last step", {done, busy}, 2);
      @(negedge clk);
      chk(!done, "R12 done pulse width", done, 0);
      return;
    end
    for (int s = 0; s < int'(v.steps); s++) begin
      @(negedge clk);
      start = 1'b0; wr_ack = 1'b0;
      chk(!rd_req && !wr_req && !done, "R2 leading idle slot", {rd_req, wr_req, done}, 0);
      if (s == 0) begin
        chk(op_mask == v.exp_mask, "R3 first mask", op_mask, v.exp_mask);
        chk(op_tex == v.exp_tex, "R8 first texture", op_tex, v.exp_tex);
      end
      @(negedge clk);
      e_mask = (v.single && m_dot) ? 16'h0000 : (v.a_word >> m_pos);
      chk(rd_req, "R2 read slot", rd_req, 1);
      chk(rd_addr == m_addr, "R4 R5 R6 R7 read address", rd_addr, m_addr);
      chk(op_mask == e_mask, "R3 R9 mask", op_mask, e_mask);
      chk(op_tex == {16{m_tex[0]}}, "R8 texture", op_tex, {16{m_tex[0]}});
      for (int d = 0; d < int'(v.dly); d++) begin
        @(negedge clk);
        chk(rd_req && rd_addr == m_addr, "R2 read held", rd_addr, m_addr);
      end
      rdv  = m_addr[15:0] ^ 16'hA5A5;
      cmbv = 16'h3C00 + 16'(s);
      rd_ack = 1'b1; rd_data = rdv; cmb_data = cmbv;
      @(negedge clk);
      rd_ack = 1'b0;
      chk(!rd_req && !wr_req, "R2 middle idle slot", {rd_req, wr_req}, 0);
      @(negedge clk);
      e_wr = m_first ? v.d_ptr : m_addr;
      chk(wr_req, "R2 write slot", wr_req, 1);
      chk(wr_addr == e_wr, "R10 write address", wr_addr, e_wr);
      chk(wr_data == cmbv, "R10 write data", wr_data, cmbv);
      chk(op_c == rdv, "R2 read word operand", op_c, rdv);
      for (int d = 0; d < int'(v.dly); d++) begin
        @(negedge clk);
        chk(wr_req && wr_addr == e_wr, "R2 write held", wr_addr, e_wr);
      end
      wr_ack = 1'b1;
      m_advance(v);
    end
    @(negedge clk);
    wr_ack = 1'b0;
    chk(done && !busy, "R12 done after last step", {done, busy}, 2);
    @(negedge clk);
    chk(!done && !rd_req, "R12 done pulse width", {done, rd_req}, 0);
  endtask

  task automatic run_reject(input logic [5:0] width, input logic [9:0] steps, input string tag);
    vec_t v;
    v = VECS[0];
    v.steps = steps;
    @(negedge clk);
    load_cfg(v, width);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && !busy && !rd_req, tag, {done, busy, rd_req}, 4);
    @(negedge clk);
    chk(!done && !busy && !rd_req, tag, {done, busy, rd_req}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; rd_ack = 1'b0; wr_ack = 1'b0;
    rd_data = '0; cmb_data = '0;
    load_cfg(VECS[0], 6'd2);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_req && !wr_req, "R1 state in reset", {busy, done, rd_req, wr_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !rd_req && !wr_req, "R1 state after reset", {busy, done, rd_req, wr_req}, 0);

    run_reject(6'd3, 10'd4, "R12 width other than 2");
    run_reject(6'd2, 10'd0, "R12 zero steps");

    for (int e = 0; e < NV; e++) run_vec(VECS[e]);

    repeat (2) @(negedge clk);
    chk(!busy && !rd_req && !wr_req, "R1 idle after lines", {busy, rd_req, wr_req}, 0);
    finish_run();
  end

endmodule